// File: doc/BRIEF.md
# MD5 Message Padding Unit

This unit sits in front of an MD5 compression core. It takes a message one byte at a time and hands out 512-bit blocks. Each block holds 64 bytes, and byte i of a block sits at bits [8i+7:8i]. The sixteen 32-bit words of a block are therefore little-endian, which is the order the compression rounds expect. After the last message byte the unit writes the padding. This is a 0x80 marker byte, then a zero fill, then the 64-bit bit length of the message in the top eight bytes of the final block.

Both edges use a valid/ready handshake. On the input side, `in_last` marks the end of a message. `in_void` marks a closing beat that carries no byte, which is how an empty message is sent. On the output side, `out_final` flags the last block of a message.

The state machine has five states:
- FILL collects bytes.
- EMIT_MID offers a full data block.
- EMIT_LAST offers a final block that holds both the end of the data and the length.
- EMIT_SPILL offers the block holding the end of the data when the length field no longer fits in it.
- EMIT_TAIL offers the padding-only block that follows a spill.

The transitions are:
- FILL to EMIT_MID on the 64th byte of a block when that byte is not the last.
- FILL to EMIT_LAST when the marker lands at byte offset 55 or lower.
- FILL to EMIT_SPILL when the marker lands at offset 56 or higher, or would land beyond the block.
- EMIT_MID to FILL on the output handshake.
- EMIT_SPILL to EMIT_TAIL on the output handshake.
- EMIT_TAIL to FILL and EMIT_LAST to FILL on the output handshake.

Top module: `md5_pad_stream`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: Every 64 accepted data bytes that do not end the message form one non-final block. Byte i of the group appears at bits [8i+7:8i] of `out_block`.
- R3: The byte 0x80 is placed directly after the last data byte of the message. If the last data byte fills a block, the 0x80 goes to byte 0 of the following block.
- R4: All bytes between the 0x80 marker and the length field are zero.
- R5: Bytes 56..63 of the final block hold the message length in bits, which is 8 times the byte count. The least significant byte is at byte 56, so word 14 holds the low half and word 15 the high half.
- R6: If the marker lands at byte offset 55 or lower, the message ends with exactly one final block that holds both the marker and the length.
- R7: If the marker lands at offset 56..63, or the data ends exactly on a block boundary, one extra padding-only block follows. That extra block is the only one flagged final.
- R8: A lone `in_last` beat with `in_void` set and no preceding bytes yields exactly one final block: 0x80 at byte 0, all other bytes zero, and a length of zero.
- R9: `in_ready` is low in every cycle in which `out_valid` is high, including while the padding-only block is offered.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_block` and `out_final` hold their values.
- R11: A closing beat with `in_void` set on a non-empty message adds no byte. The padding starts right after the previously accepted byte.
- R12: In the cycle after a final block is taken, `out_valid` is low and `in_ready` is high, ready for the next message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Unit accepts an input beat |
| in_data | input | 8 | Message byte |
| in_last | input | 1 | Beat closes the message |
| in_void | input | 1 | With `in_last`: beat carries no byte |
| out_valid | output | 1 | Block offered |
| out_ready | input | 1 | Consumer takes the block |
| out_block | output | 512 | Block, byte i at bits [8i+7:8i] |
| out_final | output | 1 | Block is the last of its message |

## Verification
Message lengths are chosen around each block boundary: 0, 1, 3, 55, 56, 57, 63, 64, 65, 119, 120, 128 and 200 bytes, plus a ten-byte message closed by a void beat.
- Lengths 55 and 56 separate the single-final-block case from the spill case.
- Length 64 shows the marker moving into the padding-only block.
- Length 0 and the void-closed message check that a beat without a byte adds nothing.

Valid and ready are toggled randomly on both sides. This catches blocks that change or vanish under backpressure, and bytes taken while a block is still pending.

// File: rtl/md5_pad_pkg.sv
package md5_pad_pkg;

    typedef enum logic [2:0] {
        ST_FILL,
        ST_EMIT_MID,
        ST_EMIT_SPILL,
        ST_EMIT_TAIL,
        ST_EMIT_LAST
    } pad_state_t;

    localparam logic [7:0] PAD_MARK = 8'h80;

endpackage

// File: rtl/md5_pad_count.sv
module md5_pad_count #(
    parameter int IDX_W = 7,
    parameter int CNT_W = 61
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic             pos_clr,
    input  logic             all_clr,
    output logic [IDX_W-1:0] pos,
    output logic [CNT_W-1:0] total
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos   <= '0;
            total <= '0;
        end else begin
            if (pos_clr)   pos <= '0;
            else if (take) pos <= pos + 1'b1;
            if (all_clr)   total <= '0;
            else if (take) total <= total + 1'b1;
        end
    end

endmodule

// File: rtl/md5_pad_buf.sv
module md5_pad_buf #(
    parameter int NB    = 64,
    parameter int BW    = 8,
    parameter int LEN_W = 64,
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [BW-1:0]    wr_byte,
    input  logic             mk_en,
    input  logic [IDX_W-1:0] mk_idx,
    input  logic [BW-1:0]    mk_byte,
    input  logic             len_en,
    input  logic [LEN_W-1:0] len_val,
    output logic [NB*BW-1:0] block
);

    logic [NB*BW-1:0] nxt;

    always_comb begin
        nxt = clr ? '0 : block;
        if (wr_en)  nxt[int'(wr_idx)*BW +: BW] = wr_byte;
        if (mk_en)  nxt[int'(mk_idx)*BW +: BW] = mk_byte;
        if (len_en) nxt[NB*BW-1 -: LEN_W] = len_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) block <= '0;
        else        block <= nxt;
    end

endmodule

// File: rtl/md5_pad_stream.sv
module md5_pad_stream #(
    parameter int BYTE_W    = 8,
    parameter int BLK_BYTES = 64,
    parameter int LEN_W     = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    output logic                          in_ready,
    input  logic [BYTE_W-1:0]             in_data,
    input  logic                          in_last,
    input  logic                          in_void,
    output logic                          out_valid,
    input  logic                          out_ready,
    output logic [BYTE_W*BLK_BYTES-1:0]   out_block,
    output logic                          out_final
);
    import md5_pad_pkg::*;

    localparam int BLK_W  = BYTE_W * BLK_BYTES;
    localparam int IDX_W  = $clog2(BLK_BYTES) + 1;
    localparam int SH_W   = $clog2(BYTE_W);
    localparam int CNT_W  = LEN_W - SH_W;
    localparam int LEN_AT = BLK_BYTES - LEN_W / BYTE_W;

    pad_state_t        state, nstate;
    logic              pend_mark;
    logic [IDX_W-1:0]  pos, pos_after, mk_idx;
    logic [CNT_W-1:0]  total;
    logic              byte_here, take, pos_clr, all_clr, buf_clr;
    logic              wr_en, mk_en, len_en, close_now;
    logic [LEN_W-1:0]  len_val;

    assign byte_here = !(in_last && in_void);
    assign pos_after = pos + IDX_W'(byte_here);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_FILL;
        else        state <= nstate;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)         pend_mark <= 1'b0;
        else if (close_now) pend_mark <= (pos_after == IDX_W'(BLK_BYTES));
    end

    always_comb begin
        nstate    = state;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_final = 1'b0;
        take      = 1'b0;
        pos_clr   = 1'b0;
        all_clr   = 1'b0;
        buf_clr   = 1'b0;
        wr_en     = 1'b0;
        mk_en     = 1'b0;
        mk_idx    = pos_after;
        len_en    = 1'b0;
        len_val   = {total, {SH_W{1'b0}}};
        close_now = 1'b0;
        unique case (state)
            ST_FILL: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    take  = byte_here;
                    wr_en = byte_here;
                    if (!in_last) begin
                        if (pos_after == IDX_W'(BLK_BYTES)) nstate = ST_EMIT_MID;
                    end else begin
                        close_now = 1'b1;
                        mk_en     = (pos_after < IDX_W'(BLK_BYTES));
                        len_val   = {total + CNT_W'(byte_here), {SH_W{1'b0}}};
                        if (pos_after < IDX_W'(LEN_AT)) begin
                            len_en = 1'b1;
                            nstate = ST_EMIT_LAST;
                        end else begin
                            nstate = ST_EMIT_SPILL;
                        end
                    end
                end
            end
            ST_EMIT_MID: begin
                out_valid = 1'b1;
                if (out_ready) begin
                    buf_clr = 1'b1;
                    pos_clr = 1'b1;
                    nstate  = ST_FILL;
                end
            end
            ST_EMIT_SPILL: begin
                out_valid = 1'b1;
                if (out_ready) begin
                    buf_clr = 1'b1;
                    pos_clr = 1'b1;
                    mk_en   = pend_mark;
                    mk_idx  = '0;
                    len_en  = 1'b1;
                    nstate  = ST_EMIT_TAIL;
                end
            end
            ST_EMIT_TAIL, ST_EMIT_LAST: begin
                out_valid = 1'b1;
                out_final = 1'b1;
                if (out_ready) begin
                    buf_clr = 1'b1;
                    pos_clr = 1'b1;
                    all_clr = 1'b1;
                    nstate  = ST_FILL;
                end
            end
            default: nstate = ST_FILL;
        endcase
    end

    md5_pad_count #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (take),
        .pos_clr (pos_clr),
        .all_clr (all_clr),
        .pos     (pos),
        .total   (total)
    );

    md5_pad_buf #(.NB(BLK_BYTES), .BW(BYTE_W), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (buf_clr),
        .wr_en   (wr_en),
        .wr_idx  (pos),
        .wr_byte (in_data),
        .mk_en   (mk_en),
        .mk_idx  (mk_idx),
        .mk_byte (BYTE_W'(PAD_MARK)),
        .len_en  (len_en),
        .len_val (len_val),
        .block   (out_block)
    );

endmodule

// File: rtl/md5_pad_stream_chk.sv
module md5_pad_stream_chk #(
    parameter int BLK_W = 512,
    parameter int LEN_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic             out_final,
    input logic [BLK_W-1:0] out_block
);

    assert_no_intake_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_block) && $stable(out_final));

    // R5: a byte count times eight leaves the low three length bits clear
    assert_len_whole_bytes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_final |-> out_block[BLK_W-LEN_W +: 3] == 3'b000);

    assert_resume_R12: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_final |=> in_ready && !out_valid);

endmodule

bind md5_pad_stream md5_pad_stream_chk #(.BLK_W(BLK_W), .LEN_W(LEN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_final (out_final),
    .out_block (out_block)
);

// File: tb/test_md5_pad_stream.sv
`timescale 1ns/1ps
module test_md5_pad_stream;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [7:0]   in_data = '0;
    logic         in_last = 1'b0;
    logic         in_void = 1'b0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [511:0] out_block;
    logic         out_final;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    md5_pad_stream i_md5_pad_stream (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .in_last   (in_last),
        .in_void   (in_void),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_block (out_block),
        .out_final (out_final)
    );

    logic [511:0] exq[$];
    logic         finq[$];

    function automatic logic [7:0] msg_byte(int m, int i);
        return 8'((m * 37 + i * 11 + 5) & 255);
    endfunction

    task automatic expect_blocks(int m, int n);
        logic [7:0]  p[$];
        logic [63:0] bits;
        logic [511:0] blk;
        for (int i = 0; i < n; i++) p.push_back(msg_byte(m, i));
        p.push_back(8'h80);
        while ((p.size() % 64) != 56) p.push_back(8'h00);
        bits = 64'(n) * 64'd8;
        for (int i = 0; i < 8; i++) p.push_back(bits[8*i +: 8]);
        for (int b = 0; b < p.size() / 64; b++) begin
            blk = '0;
            for (int i = 0; i < 64; i++) blk[8*i +: 8] = p[64*b + i];
            exq.push_back(blk);
            finq.push_back(b == p.size() / 64 - 1);
        end
    endtask

    task automatic run_msg(int m, int n, bit vd, string tag);
        int beats = vd ? n + 1 : n;
        int beat = 0;
        bit piv = 0, pir = 0, pov = 0, por = 0;
        expect_blocks(m, n);
        while (!(beat == beats && exq.size() == 0 && !pov)) begin
            @(negedge clk);
            if (piv && pir) beat++;
            if (pov && por && exq.size() != 0) begin
                void'(exq.pop_front());
                void'(finq.pop_front());
            end
            n_chk++;
            if (out_valid && in_ready) begin
                n_bad++;
                $display("FAIL R9 in_ready=%0b expected 0 while out_valid", in_ready);
            end
            if (out_valid) begin
                n_chk++;
                if (exq.size() == 0) begin
                    n_bad++;
                    $display("FAIL %s msg %0d: extra block %h expected none", tag, n, out_block);
                end else if (out_block !== exq[0] || out_final !== finq[0]) begin
                    n_bad++;
                    $display("FAIL %s R10 msg %0d: block %h final %0b expected %h final %0b",
                             tag, n, out_block, out_final, exq[0], finq[0]);
                end
            end
            if (beat < beats) begin
                in_valid = ($urandom % 5) != 0;
                in_last  = (beat == beats - 1);
                in_void  = vd && (beat == beats - 1);
                in_data  = (beat < n) ? msg_byte(m, beat) : 8'h00;
            end else begin
                in_valid = 1'b0;
                in_last  = 1'b0;
                in_void  = 1'b0;
            end
            out_ready = ($urandom % 4) != 0;
            piv = in_valid; pir = in_ready; pov = out_valid; por = out_ready;
        end
        @(negedge clk);
        n_chk++;
        if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
            n_bad++;
            $display("FAIL R12 msg %0d: out_valid=%0b in_ready=%0b expected 0 1", n, out_valid, in_ready);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        n_chk++;
        if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
            n_bad++;
            $display("FAIL R1 out_valid=%0b in_ready=%0b expected 0 1", out_valid, in_ready);
        end
        rst_n = 1'b1;
        @(negedge clk);
        n_chk++;
        if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
            n_bad++;
            $display("FAIL R1 after release out_valid=%0b in_ready=%0b expected 0 1", out_valid, in_ready);
        end
        run_msg(1, 0, 1'b1, "R8");
        run_msg(2, 1, 1'b0, "R3 R4 R5 R6");
        run_msg(3, 3, 1'b0, "R3 R4 R5 R6");
        run_msg(4, 55, 1'b0, "R6");
        run_msg(5, 56, 1'b0, "R7");
        run_msg(6, 57, 1'b0, "R7");
        run_msg(7, 63, 1'b0, "R7");
        run_msg(8, 64, 1'b0, "R2 R3 R7");
        run_msg(9, 65, 1'b0, "R2 R6");
        run_msg(10, 119, 1'b0, "R2 R6");
        run_msg(11, 120, 1'b0, "R2 R7");
        run_msg(12, 128, 1'b0, "R2 R7");
        run_msg(13, 10, 1'b1, "R11");
        run_msg(14, 200, 1'b0, "R2 R4 R5");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog R12: run still busy, expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule